// File: doc/BRIEF.md
# Four-Channel Register-Mapped Timer

This peripheral holds three down-counting interval timers and one wide up-counting timestamp counter behind a single-cycle register port. The interval timers are 16, 16 and 32 bits wide. Each one reloads itself, or wraps when it runs freely, every time it passes zero, and it raises its own level interrupt when it does. Software programs an interval timer by writing its reload register and then its control register. It acknowledges an interrupt by writing any value to that timer's clear register.

The timestamp counter is 40 bits wide and has no interrupt. It advances on its own reference tick once software sets the run bit in its upper register. Software reads it as two words and takes the difference between two samples to get the elapsed reference ticks.

The block generates no clocks. Two tick-enable inputs, one fast and one slow, feed the interval timers, and a third feeds the timestamp counter. Each tick input is high for one clock cycle per tick.

Top module: `quad_timer`

## Requirements
- R1: After reset, every enable, count, reload value and pending interrupt is zero, so every register reads 0 and `irq` is 3'b000.
- R2: A write to a timer's reload register (offset +0x0) sets both the reload value and the live count in the same edge. The live count can be read back at offset +0x4, zero-extended to 32 bits.
- R3: An interval timer steps down by one only on cycles where control bit 7 (run) is 1 and its selected tick input is high. A write to the reload register in that cycle takes priority over the step.
- R4: Control bit 3 selects the tick input. 1 selects `tick_fast` and 0 selects `tick_slow`. The tick input that is not selected has no effect on the count.
- R5: With control bit 6 set to 1 (periodic), a step taken while the count is 0 reloads the reload value and sets that timer's interrupt. The period is therefore reload+1 ticks.
- R6: With control bit 6 set to 0 (free), a step taken while the count is 0 wraps the count to all ones of the timer's width and still sets the interrupt.
- R7: A write of any data to a timer's clear register (offset +0xC) drops its interrupt on the next edge. If an underflow happens in the same cycle, the interrupt stays set.
- R8: An interrupt is a level. Once set, it stays high until a clear write.
- R9: The timestamp counter counts up by one on each `tick_ref` pulse while its run bit is 1. The run bit is written as bit 8 of offset 0x64. Offset 0x60 reads count bits 31:0. Offset 0x64 reads count bits 39:32 in bits 7:0 and the run bit in bit 8.
- R10: The register blocks sit at 0x00, 0x20 and 0x80 for interval timers 1, 2 and 3. The control register at +0x8 reads back bits 7, 6 and 3 in place.
- R11: Timers 1 and 2 keep only the low 16 bits of a reload write. Timer 3 keeps all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_fast | input | 1 | Fast tick enable for the interval timers |
| tick_slow | input | 1 | Slow tick enable for the interval timers |
| tick_ref | input | 1 | Tick enable for the timestamp counter |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 3 | Level interrupts of interval timers 1 to 3 |

## Verification
Register writes and tick pulses take effect at the next rising edge. Read data is combinational from the registers, so a value changed by an edge can be read back in the same cycle. `irq` is a register and shows an underflow or a clear one edge after the cycle that caused it. The bench drives every stimulus on the falling edge and samples on the following falling edge, so each result is read exactly one edge after its cause. The cases where an underflow collides with a clear write, or a reload write collides with a tick, are driven in a single cycle.

// File: rtl/qt_pkg.sv
package qt_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  // register index inside a channel block, taken from addr[3:2]
  localparam logic [1:0] IDX_RELOAD = 2'd0;
  localparam logic [1:0] IDX_COUNT  = 2'd1;
  localparam logic [1:0] IDX_CTRL   = 2'd2;
  localparam logic [1:0] IDX_ACK    = 2'd3;

  // control bit positions
  localparam int CB_RUN    = 7;
  localparam int CB_PERIOD = 6;
  localparam int CB_FAST   = 3;

  // timestamp counter
  localparam int TS_RUN_BIT = 8;
  localparam logic [ADDR_W-1:0] TS_LO_ADDR = 8'h60;
  localparam logic [ADDR_W-1:0] TS_HI_ADDR = 8'h64;

  // channel block bases (upper nibble decoded)
  localparam logic [ADDR_W-1:0] CH_BASE [3] = '{8'h00, 8'h20, 8'h80};
endpackage

// File: rtl/qt_interval.sv
module qt_interval
  import qt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [1:0]        reg_idx,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick_fast,
  input  logic              tick_slow,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [W-1:0] reload_q, cnt_q;
  logic         run_q, period_q, fast_q, irq_q;

  // named internal events
  logic ld_wr, ctl_wr, ack_wr, tick_sel, step, uflow;
  logic unused_bits;

  assign ld_wr    = sel && wr && (reg_idx == IDX_RELOAD);
  assign ctl_wr   = sel && wr && (reg_idx == IDX_CTRL);
  assign ack_wr   = sel && wr && (reg_idx == IDX_ACK);
  assign tick_sel = fast_q ? tick_fast : tick_slow;
  assign step     = run_q && tick_sel && !ld_wr;
  assign uflow    = step && (cnt_q == '0);
  assign unused_bits = ^wdata;

  function automatic logic [W-1:0] next_count(input logic [W-1:0] c,
                                               input logic [W-1:0] rl,
                                               input logic periodic);
    if (c != '0)      return c - 1'b1;
    else if (periodic) return rl;
    else              return '1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
      run_q    <= 1'b0;
      period_q <= 1'b0;
      fast_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (ld_wr) begin
        reload_q <= wdata[W-1:0];
        cnt_q    <= wdata[W-1:0];
      end else if (step) begin
        cnt_q <= next_count(cnt_q, reload_q, period_q);
      end
      if (ctl_wr) begin
        run_q    <= wdata[CB_RUN];
        period_q <= wdata[CB_PERIOD];
        fast_q   <= wdata[CB_FAST];
      end
      if (uflow)       irq_q <= 1'b1;
      else if (ack_wr) irq_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel) begin
      case (reg_idx)
        IDX_RELOAD: rdata = DATA_W'(reload_q);
        IDX_COUNT:  rdata = DATA_W'(cnt_q);
        IDX_CTRL: begin
          rdata[CB_RUN]    = run_q;
          rdata[CB_PERIOD] = period_q;
          rdata[CB_FAST]   = fast_q;
        end
        default:    rdata = '0;
      endcase
    end
  end

  assign irq = irq_q;

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && period_q) |=> (cnt_q == $past(reload_q)));
  p_irq_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    uflow |=> irq_q);
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && !period_q) |=> (cnt_q == '1));
  p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !uflow) |=> !irq_q);
  p_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !ack_wr) |=> irq_q);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !ld_wr) |=> $stable(cnt_q));
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wr |=> (cnt_q == $past(wdata[W-1:0])));
endmodule

// File: rtl/qt_stamp.sv
module qt_stamp
  import qt_pkg::*;
#(
  parameter int W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_lo,
  input  logic              sel_hi,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  output logic [DATA_W-1:0] rdata
);
  localparam int HI_W = W - DATA_W;

  logic [W-1:0] cnt_q;
  logic         run_q;
  logic         adv, run_wr;
  logic         unused_bits;

  assign run_wr = sel_hi && wr;
  assign adv    = run_q && tick;
  assign unused_bits = ^wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (run_wr) run_q <= wdata[TS_RUN_BIT];
      if (adv)    cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_lo) begin
      rdata = cnt_q[DATA_W-1:0];
    end else if (sel_hi) begin
      rdata[HI_W-1:0]   = cnt_q[W-1:DATA_W];
      rdata[TS_RUN_BIT] = run_q;
    end
  end

  p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(cnt_q));
endmodule

// File: rtl/quad_timer.sv
module quad_timer
  import qt_pkg::*;
#(
  parameter int T1_W = 16,
  parameter int T2_W = 16,
  parameter int T3_W = 32,
  parameter int TS_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_fast,
  input  logic              tick_slow,
  input  logic              tick_ref,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [2:0]        irq
);
  localparam int NCH = 3;
  localparam int CH_W [NCH] = '{T1_W, T2_W, T3_W};

  logic [DATA_W-1:0] ch_rdata [NCH];
  logic [NCH-1:0]    ch_hit;
  logic [DATA_W-1:0] ts_rdata;
  logic              ts_lo, ts_hi;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ch_hit[g] = (reg_addr[ADDR_W-1:4] == CH_BASE[g][ADDR_W-1:4]);
    qt_interval #(.W(CH_W[g])) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (ch_hit[g]),
      .reg_idx   (reg_addr[3:2]),
      .wr        (reg_wr),
      .wdata     (reg_wdata),
      .tick_fast (tick_fast),
      .tick_slow (tick_slow),
      .rdata     (ch_rdata[g]),
      .irq       (irq[g])
    );
  end

  assign ts_lo = (reg_addr == TS_LO_ADDR);
  assign ts_hi = (reg_addr == TS_HI_ADDR);

  qt_stamp #(.W(TS_W)) u_ts (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_lo (ts_lo),
    .sel_hi (ts_hi),
    .wr     (reg_wr),
    .wdata  (reg_wdata),
    .tick   (tick_ref),
    .rdata  (ts_rdata)
  );

  always_comb begin
    reg_rdata = ts_rdata;
    for (int i = 0; i < NCH; i++) reg_rdata = reg_rdata | ch_rdata[i];
  end

  p_onehot_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ch_hit, ts_lo, ts_hi}));
endmodule

// File: tb/test_quad_timer.sv
`timescale 1ns/1ps
module test_quad_timer;
  localparam int OP_WR = 0, OP_RD = 1, OP_FT = 2, OP_ST = 3, OP_RT = 4, OP_IRQ = 5;
  localparam int NV = 45;

  function automatic logic [46:0] v(input int rq, input int op,
                                    input logic [7:0] a, input logic [31:0] d);
    return {4'(rq), 3'(op), a, d};
  endfunction

  localparam logic [46:0] VEC [NV] = '{
    v(2, OP_WR, 8'h00, 32'h0001_2345),
    v(11,OP_RD, 8'h04, 32'h0000_2345),  // R11 upper bits dropped
    v(2, OP_WR, 8'h00, 32'd3),
    v(2, OP_RD, 8'h04, 32'd3),           // R2
    v(10,OP_WR, 8'h08, 32'hC8),
    v(10,OP_RD, 8'h08, 32'hC8),          // R10
    v(3, OP_FT, 8'h00, 32'd2),
    v(3, OP_RD, 8'h04, 32'd1),           // R3
    v(4, OP_ST, 8'h00, 32'd2),
    v(4, OP_RD, 8'h04, 32'd1),           // R4 slow ignored
    v(4, OP_FT, 8'h00, 32'd1),
    v(5, OP_RD, 8'h04, 32'd0),
    v(5, OP_IRQ,8'h00, 32'd0),
    v(5, OP_FT, 8'h00, 32'd1),
    v(5, OP_RD, 8'h04, 32'd3),           // R5 reload
    v(5, OP_IRQ,8'h00, 32'd1),
    v(7, OP_WR, 8'h0C, 32'hDEAD),
    v(7, OP_IRQ,8'h00, 32'd0),           // R7
    v(6, OP_WR, 8'h28, 32'h80),
    v(6, OP_ST, 8'h00, 32'd1),
    v(6, OP_RD, 8'h24, 32'hFFFF),        // R6 wrap
    v(6, OP_IRQ,8'h00, 32'd2),
    v(10,OP_RD, 8'h28, 32'h80),
    v(7, OP_WR, 8'h2C, 32'd0),
    v(7, OP_IRQ,8'h00, 32'd0),
    v(11,OP_WR, 8'h80, 32'd1),
    v(5, OP_WR, 8'h88, 32'hC8),
    v(5, OP_FT, 8'h00, 32'd2),
    v(5, OP_RD, 8'h84, 32'd1),           // R5 period 2 ticks
    v(5, OP_IRQ,8'h00, 32'd4),
    v(3, OP_WR, 8'h08, 32'h48),
    v(3, OP_WR, 8'h88, 32'h48),
    v(3, OP_FT, 8'h00, 32'd3),
    v(3, OP_RD, 8'h84, 32'd1),           // R3 no run
    v(3, OP_RD, 8'h04, 32'd1),
    v(11,OP_WR, 8'h80, 32'hFFFF_FFF0),
    v(11,OP_RD, 8'h84, 32'hFFFF_FFF0),   // R11 full 32 bits
    v(9, OP_RT, 8'h00, 32'd3),
    v(9, OP_RD, 8'h60, 32'd0),           // R9 not running
    v(9, OP_WR, 8'h64, 32'h100),
    v(9, OP_RT, 8'h00, 32'd3),
    v(9, OP_RD, 8'h60, 32'd3),
    v(9, OP_RD, 8'h64, 32'h100),
    v(7, OP_WR, 8'h8C, 32'd0),
    v(7, OP_IRQ,8'h00, 32'd0)
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_fast = 1'b0, tick_slow = 1'b0, tick_ref = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  irq;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  quad_timer i_quad_timer (
    .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .tick_ref(tick_ref), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input int rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input int rq, input logic [7:0] a, input logic [31:0] e);
    @(negedge clk); reg_addr = a; #1;
    check(rq, reg_rdata, e);
  endtask

  task automatic pulse(input int which, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick_fast = (which == OP_FT); tick_slow = (which == OP_ST); tick_ref = (which == OP_RT);
      @(negedge clk);
      tick_fast = 0; tick_slow = 0; tick_ref = 0;
    end
  endtask

  task automatic reset_checks(input int rq);
    rd(rq, 8'h00, 0); rd(rq, 8'h04, 0); rd(rq, 8'h08, 0); rd(rq, 8'h24, 0);
    rd(rq, 8'h84, 0); rd(rq, 8'h60, 0); rd(rq, 8'h64, 0);
    check(rq, 32'(irq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reset_checks(1);  // R1

    for (int i = 0; i < NV; i++) begin
      int rq, op;
      logic [7:0] a;
      logic [31:0] d;
      rq = int'(VEC[i][46:43]); op = int'(VEC[i][42:40]);
      a = VEC[i][39:32]; d = VEC[i][31:0];
      case (op)
        OP_WR:  wr(a, d);
        OP_RD:  rd(rq, a, d);
        OP_IRQ: begin @(negedge clk); check(rq, 32'(irq), d); end
        default: pulse(op, int'(d));
      endcase
    end

    // R7: underflow and clear write in the same cycle, underflow wins
    wr(8'h00, 32'd0);
    wr(8'h08, 32'hC8);
    @(negedge clk);
    tick_fast = 1'b1; reg_addr = 8'h0C; reg_wdata = 32'h5; reg_wr = 1'b1;
    @(negedge clk);
    tick_fast = 1'b0; reg_wr = 1'b0;
    check(7, 32'(irq), 32'd1);
    // R8: level holds with no clear
    repeat (5) @(negedge clk);
    check(8, 32'(irq), 32'd1);
    wr(8'h0C, 32'd0);
    check(8, 32'(irq), 32'd0);

    // R1: reset in mid-run
    wr(8'h00, 32'd9);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    reset_checks(1);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule